// File: doc/BRIEF.md
# Selectable Output Data Format Coder

This block sits between a converter core and the output pads. It takes 12-bit two's complement samples from the core and re-codes each one into the output coding chosen at that moment: two's complement, Gray code or offset binary. A settings register holds two 3-bit selection fields. The coding field sits in bits [7:5] and the pad mode field sits in bits [2:0]. When a field is zero or holds an undefined value, the choice falls to the matching strap input. Each strap input models a three-level pin as a 2-bit code.

Samples flow through a valid/ready stream with one register stage. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the output stage is empty or the consumer is taking its word in the same cycle, so the stage can accept a new sample every cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. A soft reset empties the stream stage and leaves the settings register as it is. A hard reset clears both. The pad mode is decoded into a plain status output that external pad logic uses.

Top module: `sample_format_coder`

## Requirements
- R1: A write (`cfg_we` high at a clock edge) loads `cfg_wdata` into the settings register. The coding field is bits [7:5] and the pad field is bits [2:0]. The new value takes effect from the next cycle.
- R2: Coding field 001 selects two's complement, so the output equals the input sample.
- R3: Coding field 010 selects Gray code. The output is g = b XOR (b >> 1), where b is the offset binary form of the sample.
- R4: Coding field 100 selects offset binary. This is the sample plus 2048, modulo 4096, which is the sample with its MSB inverted.
- R5: Coding field 000, 011, 101, 110 or 111 hands the choice to `strap_code`. Strap code 01 (mid) selects Gray, 10 (high) selects offset binary, and 00 (low) or 11 select two's complement.
- R6: `pad_mode` reports 00 for LVDS low drive, 01 for LVDS high drive and 10 for LVCMOS. Pad field 001, 010 and 100 map to these in that order. Any other pad field value follows `strap_pad` with the same mapping (01 gives 01, 10 gives 10, 00 or 11 give 00). The value 11 never appears on `pad_mode`.
- R7: A sample accepted at an edge appears on `out_data` with `out_valid` high after that same edge, which is one cycle of latency. The stage empties when its word is taken and no new sample arrives.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds.
- R9: `soft_rst` at an edge empties the output stage (`out_valid` low afterwards). The settings register keeps its value, apart from a write made in the same cycle.
- R10: Hard reset (`rst_n` low, asynchronous) clears the settings register to zero, so both choices come from the straps, and it clears `out_valid`.
- R11: The coding is fixed when a sample is accepted. A register write in the same or a later cycle does not change a word already in the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset, empties the stream stage |
| cfg_we | input | 1 | Settings register write strobe |
| cfg_wdata | input | 8 | Settings register write data |
| strap_code | input | 2 | Three-level coding strap: 00 low, 01 mid, 10 high |
| strap_pad | input | 2 | Three-level pad mode strap: 00 low, 01 mid, 10 high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_data | input | 12 | Two's complement sample from the core |
| out_valid | output | 1 | Coded sample valid |
| out_ready | input | 1 | Consumer takes the coded sample |
| out_data | output | 12 | Coded sample |
| pad_mode | output | 2 | Decoded pad mode status |

## Verification
The assertions check the stream rules on every cycle. These are the hold under back-pressure, the one-cycle arrival of an accepted sample, and the emptying on soft reset. They also check that the settings register stays unchanged through a soft reset and that the MSB is inverted whenever a coding other than two's complement is applied. Some results can only be shown by the bench's scenarios, which compare against a model on every clock. These are the exact code values for each coding, the fall-back to the straps for every undefined field value, the pad mode mapping, and the rule that a coding change never reaches a word already held in the stage.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    CODE_TWOS = 2'd0,
    CODE_GRAY = 2'd1,
    CODE_OFFS = 2'd2
  } code_e;

  typedef enum logic [1:0] {
    PAD_LVDS_LO = 2'd0,
    PAD_LVDS_HI = 2'd1,
    PAD_CMOS    = 2'd2
  } pad_e;

  localparam int FIELD_W = 3;
  localparam logic [FIELD_W-1:0] SEL_FIRST  = 3'b001;
  localparam logic [FIELD_W-1:0] SEL_SECOND = 3'b010;
  localparam logic [FIELD_W-1:0] SEL_THIRD  = 3'b100;

  localparam logic [1:0] STRAP_MID  = 2'b01;
  localparam logic [1:0] STRAP_HIGH = 2'b10;
endpackage

// File: rtl/sfc_cfg_reg.sv
module sfc_cfg_reg
  import sfc_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int CODE_LSB = 5,
  parameter int PAD_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       strap_code,
  input  logic [1:0]       strap_pad,
  output code_e            code,
  output pad_e             pad
);
  localparam int CODE_MSB = CODE_LSB + FIELD_W - 1;
  localparam int PAD_MSB  = PAD_LSB + FIELD_W - 1;

  logic [FIELD_W-1:0] code_fld_q;
  logic [FIELD_W-1:0] pad_fld_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;

  // Soft reset intentionally leaves these fields alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_fld_q <= '0;
      pad_fld_q  <= '0;
    end else if (we) begin
      code_fld_q <= wdata[CODE_MSB:CODE_LSB];
      pad_fld_q  <= wdata[PAD_MSB:PAD_LSB];
    end
  end

  always_comb begin
    case (code_fld_q)
      SEL_FIRST:  code = CODE_TWOS;
      SEL_SECOND: code = CODE_GRAY;
      SEL_THIRD:  code = CODE_OFFS;
      default: begin
        if (strap_code == STRAP_MID)       code = CODE_GRAY;
        else if (strap_code == STRAP_HIGH) code = CODE_OFFS;
        else                               code = CODE_TWOS;
      end
    endcase
  end

  always_comb begin
    case (pad_fld_q)
      SEL_FIRST:  pad = PAD_LVDS_LO;
      SEL_SECOND: pad = PAD_LVDS_HI;
      SEL_THIRD:  pad = PAD_CMOS;
      default: begin
        if (strap_pad == STRAP_MID)       pad = PAD_LVDS_HI;
        else if (strap_pad == STRAP_HIGH) pad = PAD_CMOS;
        else                              pad = PAD_LVDS_LO;
      end
    endcase
  end

  assert_write_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (code_fld_q == $past(wdata[CODE_MSB:CODE_LSB])) &&
           (pad_fld_q == $past(wdata[PAD_MSB:PAD_LSB])))
    else $error("settings write not loaded");

  assert_keep_on_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !we) |=> ($stable(code_fld_q) && $stable(pad_fld_q)))
    else $error("settings changed by soft reset");
endmodule

// File: rtl/sfc_encoder.sv
module sfc_encoder
  import sfc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] din,
  input  code_e        code,
  output logic [W-1:0] dout
);
  logic [W-1:0] offs;
  logic [W-1:0] gray;

  assign offs = {~din[W-1], din[W-2:0]};

  assign gray[W-1] = offs[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : g_gray
    assign gray[i] = offs[i] ^ offs[i+1];
  end

  always_comb begin
    case (code)
      CODE_GRAY: dout = gray;
      CODE_OFFS: dout = offs;
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/sfc_pipe.sv
module sfc_pipe #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (soft_rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_data <= '0;
    else if (take) out_data <= in_data;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_rst) |=> (out_valid && $stable(out_data)))
    else $error("stalled word not held");

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !soft_rst) |=> out_valid)
    else $error("accepted sample missing");

  assert_soft_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !out_valid)
    else $error("soft reset left word valid");
endmodule

// File: rtl/sample_format_coder.sv
module sample_format_coder
  import sfc_pkg::*;
#(
  parameter int W     = 12,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [1:0]       strap_code,
  input  logic [1:0]       strap_pad,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [1:0]       pad_mode
);
  code_e        code;
  pad_e         pad;
  logic [W-1:0] coded;

  sfc_cfg_reg #(.REG_W(REG_W), .CODE_LSB(5), .PAD_LSB(0)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .strap_code (strap_code),
    .strap_pad  (strap_pad),
    .code       (code),
    .pad        (pad)
  );

  sfc_encoder #(.W(W)) u_enc (
    .din  (in_data),
    .code (code),
    .dout (coded)
  );

  sfc_pipe #(.W(W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (coded),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assign pad_mode = pad;

  assert_msb_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !soft_rst && code != CODE_TWOS)
      |=> (out_data[W-1] != $past(in_data[W-1])))
    else $error("coded MSB not inverted");

  assert_pad_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_mode != 2'b11)
    else $error("illegal pad mode");
endmodule

// File: tb/tb_sample_format_coder.sv
module tb_sample_format_coder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, soft_rst = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] strap_code = '0, strap_pad = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  logic [1:0] pad_mode;

  sample_format_coder dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .strap_code(strap_code), .strap_pad(strap_pad),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pad_mode(pad_mode)
  );

  int checks = 0;
  int fails = 0;
  logic m_valid = 1'b0;
  logic [W-1:0] m_data = '0;
  logic [7:0] m_reg = '0;
  string m_tag = "R7";

  function automatic int code_of(logic [7:0] r, logic [1:0] s);
    if (r[7:5] == 3'b001) return 0;
    if (r[7:5] == 3'b010) return 1;
    if (r[7:5] == 3'b100) return 2;
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 2;
    return 0;
  endfunction

  function automatic int pad_of(logic [7:0] r, logic [1:0] s);
    if (r[2:0] == 3'b001) return 0;
    if (r[2:0] == 3'b010) return 1;
    if (r[2:0] == 3'b100) return 2;
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 2;
    return 0;
  endfunction

  function automatic logic [W-1:0] ref_code(logic [W-1:0] x, int c);
    int ob;
    logic [W-1:0] b, g;
    ob = (int'(x) + 2048) % 4096;
    b = ob[W-1:0];
    if (c == 0) return x;
    if (c == 2) return b;
    for (int i = 0; i < W; i++) g[i] = (i == W - 1) ? b[i] : (b[i] ^ b[i+1]);
    return g;
  endfunction

  function automatic string tag_of(logic [7:0] r, int c);
    if (!(r[7:5] inside {3'b001, 3'b010, 3'b100})) return "R5";
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic cycle(input logic iv, input logic [W-1:0] d, input logic ordy,
                       input logic we, input logic [7:0] wd, input logic sr,
                       input logic hr);
    logic acc;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    cfg_we = we; cfg_wdata = wd; soft_rst = sr; rst_n = hr;
    #1;
    if (!hr) begin
      m_valid = 1'b0; m_reg = '0;
      check("R10", pad_mode, pad_of(8'h00, strap_pad));
    end else begin
      check("R8", in_ready, !m_valid || ordy);
      check("R6", pad_mode, pad_of(m_reg, strap_pad));
      acc = iv && (!m_valid || ordy);
      if (sr) m_valid = 1'b0;
      else if (acc) begin
        m_valid = 1'b1;
        m_data = ref_code(d, code_of(m_reg, strap_code));
        m_tag = tag_of(m_reg, code_of(m_reg, strap_code));
      end else if (ordy) m_valid = 1'b0;
      if (we) m_reg = wd;
    end
    @(posedge clk);
    #1;
    check(sr ? "R9" : "R7", out_valid, m_valid);
    if (m_valid) check(m_tag, out_data, m_data);
  endtask

  task automatic burst(int n, logic [7:0] wd, int wr_pct, int stall_pct);
    for (int k = 0; k < n; k++) begin
      logic we_k;
      we_k = ($urandom % 100) < wr_pct;
      cycle(($urandom % 4) != 0, W'($urandom), ($urandom % 100) >= stall_pct,
            we_k, we_k ? 8'($urandom) : wd, 1'b0, 1'b1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycle(0, '0, 0, 0, '0, 0, 0);
    cycle(0, '0, 0, 0, '0, 0, 0);
    // R10: register cleared, stage empty
    cycle(0, '0, 1, 0, '0, 0, 1);
    // R1/R2: two's complement selected, corner samples
    cycle(0, '0, 1, 1, 8'b001_00_001, 0, 1);
    cycle(1, 12'h800, 1, 0, '0, 0, 1);
    cycle(1, 12'h7FF, 1, 0, '0, 0, 1);
    // R3: Gray
    cycle(0, '0, 1, 1, 8'b010_00_010, 0, 1);
    cycle(1, 12'h000, 1, 0, '0, 0, 1);
    cycle(1, 12'hFFF, 1, 0, '0, 0, 1);
    cycle(1, 12'h800, 1, 0, '0, 0, 1);
    // R4: offset binary
    cycle(0, '0, 1, 1, 8'b100_00_100, 0, 1);
    cycle(1, 12'h800, 1, 0, '0, 0, 1);
    cycle(1, 12'h123, 1, 0, '0, 0, 1);
    // R8/R11: stall, then change coding while a word is held
    cycle(1, 12'h456, 0, 0, '0, 0, 1);
    cycle(1, 12'h789, 0, 1, 8'b001_00_001, 0, 1);
    cycle(0, '0, 0, 0, '0, 0, 1);
    cycle(0, '0, 1, 0, '0, 0, 1);
    // R5/R6: strap control for every strap value and undefined fields
    for (int f = 0; f < 8; f++) begin
      if (f inside {1, 2, 4}) continue;
      for (int s = 0; s < 4; s++) begin
        strap_code = 2'(s); strap_pad = 2'(3 - s);
        cycle(0, '0, 1, 1, {3'(f), 2'b00, 3'(f)}, 0, 1);
        cycle(1, W'($urandom), 1, 0, '0, 0, 1);
        cycle(1, 12'h801, 1, 0, '0, 0, 1);
      end
    end
    // random traffic with writes and back-pressure
    strap_code = 2'b01; strap_pad = 2'b10;
    burst(800, 8'h00, 5, 30);
    // R9: soft reset mid-stream keeps the register
    cycle(0, '0, 1, 1, 8'b100_00_010, 0, 1);
    cycle(1, 12'h3AB, 0, 0, '0, 0, 1);
    cycle(1, 12'h3AC, 0, 0, '0, 1, 1);
    cycle(1, 12'h0F0, 1, 0, '0, 0, 1);
    cycle(0, '0, 1, 0, '0, 0, 1);
    burst(300, 8'h00, 0, 50);
    // R10: hard reset mid-stream clears the register
    cycle(1, 12'h111, 0, 0, '0, 0, 1);
    cycle(0, '0, 0, 0, '0, 0, 0);
    cycle(1, 12'h222, 1, 0, '0, 0, 1);
    cycle(0, '0, 1, 0, '0, 0, 1);
    for (int s = 0; s < 3; s++) begin
      strap_code = 2'(s); strap_pad = 2'(s);
      burst(400, 8'h00, 3, 20);
      cycle(1, W'($urandom), 1, 0, '0, 1, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule